// File: doc/BRIEF.md
# Clock-to-Signal Edge Delay Meter

The meter watches two asynchronous digital inputs on a fast sampling clock: a reference clock and a signal that is expected to follow it. It measures how many sample periods pass between a chosen edge on the reference and the next chosen edge on the dependent signal. Each result appears as an unsigned count with a one-cycle valid strobe. The edge type of each input is chosen on its own: rising, falling, or any change.

Measurement strictly alternates between waiting for a reference edge and waiting for a signal edge. An edge that arrives out of turn is counted and flagged. A signal edge that shows up while no reference edge is pending is a missed signal. A second reference edge that arrives before the signal has answered the first one is a missed clock. One sample can close one measurement and open the next. Both edges on the same sample give a delay of zero.

The edge-type inputs may only change while reset is held. The two event counters can be zeroed at run time through a synchronous clear.

Top module: `edge_delay_meter`

## Requirements
- R1: Each input has its own 2-bit edge-type code. Code 0 detects a 0-to-1 step, code 1 detects a 1-to-0 step, and codes 2 and 3 detect any change of value.
- R2: Each input passes through a synchroniser of equal depth (default two flops). With the default depth, the outputs that result from a sample presented before rising edge n change at rising edge n+2.
- R3: The first valid sample after reset only loads the stored previous values. It never produces a result, a pulse or a counter change.
- R4: While waiting for the reference, a reference edge starts a measurement and switches to waiting for the signal.
- R5: While waiting for the signal, a signal edge gives a result equal to its sample index minus the start sample index. `meas_valid` is high for exactly one cycle. `meas_delay` and `meas_ovf` keep their last result in between.
- R6: While waiting for the reference, a reference edge and a signal edge on the same sample give a result of 0, and the block keeps waiting for the reference.
- R7: While waiting for the signal, a signal edge and a reference edge on the same sample report the running result, and a new measurement starts from that sample.
- R8: While waiting for the reference, a signal edge with no reference edge on that sample raises `miss_sig_pulse` for one cycle and increments `miss_sig_count`. This happens only once at least one result has been produced since reset.
- R9: While waiting for the signal, a reference edge with no signal edge on that sample raises `miss_ref_pulse` and increments `miss_ref_count`. The start sample of the running measurement is not moved.
- R10: The delay saturates at 2^DELAY_W-1. A result at that value is reported with `meas_ovf` high.
- R11: Both event counters stop at 2^MISS_W-1.
- R12: `cnt_clear` zeroes both event counters at the next clock edge and wins over an increment in that cycle.
- R13: While `rst_n` is low, every output is zero at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_mode | input | 2 | Edge type for the reference input |
| sig_mode | input | 2 | Edge type for the dependent signal |
| cnt_clear | input | 1 | Synchronous clear of both event counters |
| ref_in | input | 1 | Asynchronous reference clock input |
| sig_in | input | 1 | Asynchronous dependent signal input |
| meas_valid | output | 1 | One-cycle strobe for a new result |
| meas_delay | output | DELAY_W | Last measured delay in sample periods |
| meas_ovf | output | 1 | Last result was saturated |
| miss_ref_pulse | output | 1 | Out-of-turn reference edge seen |
| miss_sig_pulse | output | 1 | Out-of-turn signal edge seen |
| miss_ref_count | output | MISS_W | Saturating count of out-of-turn reference edges |
| miss_sig_count | output | MISS_W | Saturating count of out-of-turn signal edges |

## Verification
A wrong phase state shows at the ports within the next edge on either input. It appears as a missing or extra `meas_valid`, or as a miss pulse where a result was due. A wrong start index or a wrong elapsed count shows up in the value of the next result, and one wrong sample of delay is an off-by-one in `meas_delay`. Because a bench model is compared on every cycle against every output, including the held delay and both counters, a corrupted register appears at most two cycles after the sample that exposes it.

// File: rtl/edm_pkg.sv
// Package: shared types and the edge-type decoder of the delay meter.
// Assumes edge codes 2 and 3 both mean "any change".
package edm_pkg;

    typedef enum logic [1:0] {
        EDGE_RISE     = 2'd0,
        EDGE_FALL     = 2'd1,
        EDGE_ANY      = 2'd2,
        EDGE_ANY_ALT  = 2'd3
    } edge_mode_t;

    typedef enum logic {
        ST_WAIT_REF = 1'b0,
        ST_WAIT_SIG = 1'b1
    } meas_state_t;

    localparam int NUM_CH = 2;
    localparam int CH_REF = 0;
    localparam int CH_SIG = 1;

    // Decide whether an old/new value pair is an edge of the selected type.
    function automatic logic edge_match(input logic [1:0] mode, input logic old_v, input logic new_v);
        case (edge_mode_t'(mode))
            EDGE_RISE: return !old_v && new_v;
            EDGE_FALL: return old_v && !new_v;
            default:   return old_v ^ new_v;
        endcase
    endfunction

endpackage

// File: rtl/edm_sync.sv
// Module: multi-flop synchroniser with a matching valid chain.
// Every bit sees the same number of stages, so relative timing between bits
// is kept. dvalid rises once the chain holds data sampled after reset.
// Assumes STAGES >= 1.
module edm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dvalid
);

    localparam int LAST = STAGES - 1;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [WIDTH-1:0] q;
        logic             v;
        if (i == 0) begin : g_first
            // Capture the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                    v <= 1'b0;
                end else begin
                    q <= din;
                    v <= 1'b1;
                end
            end
        end else begin : g_next
            // Shift one stage further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                    v <= 1'b0;
                end else begin
                    q <= g_stage[i-1].q;
                    v <= g_stage[i-1].v;
                end
            end
        end
    end

    assign dout   = g_stage[LAST].q;
    assign dvalid = g_stage[LAST].v;

    // R2
    sync_valid_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid |=> dvalid);

endmodule

// File: rtl/edm_edge_detect.sv
// Module: per-channel edge detector with a priming sample.
// The first valid sample after reset only loads the previous-value register.
// Assumes the mode inputs are held steady outside reset.
module edm_edge_detect (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid,
    input  logic [1:0] smp,
    input  logic [1:0] ref_mode,
    input  logic [1:0] sig_mode,
    output logic [1:0] edge_hit
);

    logic [1:0] prev_q;
    logic       primed_q;
    logic [1:0] mode_sel [edm_pkg::NUM_CH];

    assign mode_sel[edm_pkg::CH_REF] = ref_mode;
    assign mode_sel[edm_pkg::CH_SIG] = sig_mode;

    // Remember the last sample and note that one has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (smp_valid) begin
            prev_q   <= smp;
            primed_q <= 1'b1;
        end
    end

    for (genvar ch = 0; ch < edm_pkg::NUM_CH; ch++) begin : g_ch
        assign edge_hit[ch] = primed_q && smp_valid &&
                              edm_pkg::edge_match(mode_sel[ch], prev_q[ch], smp[ch]);

        // R1
        edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            edge_hit[ch] |-> (smp[ch] != prev_q[ch]));
    end

    // R3
    prime_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(primed_q) |-> ($past(edge_hit) == 2'b00));

endmodule

// File: rtl/edm_sat_counter.sv
// Module: saturating up-counter with a synchronous clear.
// Clear has priority over increment.
module edm_sat_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] CMAX = '1;

    // Count events, stop at the top, zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (inc && (count != CMAX)) begin
            count <= count + 1'b1;
        end
    end

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CMAX && !clr) |=> (count == CMAX));

    // R11
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (count == $past(count) || count == $past(count) + 1'b1));

    // R12
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/edge_delay_meter.sv
// Module: clock-to-signal edge delay meter (top).
// Synchronises both inputs, finds the chosen edges, and alternates between
// waiting for a reference edge and waiting for a signal edge. It reports the
// elapsed sample count and counts out-of-turn edges.
// Assumes ref_mode and sig_mode change only while rst_n is low.
module edge_delay_meter #(
    parameter int DELAY_W     = 24,
    parameter int MISS_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         ref_mode,
    input  logic [1:0]         sig_mode,
    input  logic               cnt_clear,
    input  logic               ref_in,
    input  logic               sig_in,
    output logic               meas_valid,
    output logic [DELAY_W-1:0] meas_delay,
    output logic               meas_ovf,
    output logic               miss_ref_pulse,
    output logic               miss_sig_pulse,
    output logic [MISS_W-1:0]  miss_ref_count,
    output logic [MISS_W-1:0]  miss_sig_count
);

    import edm_pkg::*;

    localparam logic [DELAY_W-1:0] DMAX = '1;
    localparam logic [DELAY_W-1:0] DONE = DELAY_W'(1);

    logic [1:0]         sync_smp;
    logic               sync_vld;
    logic [1:0]         edge_hit;
    logic               ref_e, sig_e;

    meas_state_t        st_q, st_d;
    logic [DELAY_W-1:0] elapsed_q, elapsed_d;
    logic               seen_q, seen_d;
    logic               done, miss_r, miss_s;
    logic [DELAY_W-1:0] done_delay;

    edm_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    ({sig_in, ref_in}),
        .dout   (sync_smp),
        .dvalid (sync_vld)
    );

    edm_edge_detect i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (sync_vld),
        .smp       (sync_smp),
        .ref_mode  (ref_mode),
        .sig_mode  (sig_mode),
        .edge_hit  (edge_hit)
    );

    assign ref_e = edge_hit[CH_REF];
    assign sig_e = edge_hit[CH_SIG];

    // Next-state logic: both phases may complete within one sample.
    always_comb begin
        st_d       = st_q;
        elapsed_d  = elapsed_q;
        seen_d     = seen_q;
        done       = 1'b0;
        done_delay = elapsed_q;
        miss_r     = 1'b0;
        miss_s     = 1'b0;
        case (st_q)
            ST_WAIT_REF: begin
                if (ref_e) begin
                    if (sig_e) begin
                        done       = 1'b1;
                        done_delay = '0;
                        seen_d     = 1'b1;
                    end else begin
                        st_d      = ST_WAIT_SIG;
                        elapsed_d = DONE;
                    end
                end else if (sig_e && seen_q) begin
                    miss_s = 1'b1;
                end
            end
            default: begin
                if (sig_e) begin
                    done   = 1'b1;
                    seen_d = 1'b1;
                    if (ref_e) begin
                        elapsed_d = DONE;
                    end else begin
                        st_d = ST_WAIT_REF;
                    end
                end else begin
                    miss_r = ref_e;
                    if (elapsed_q != DMAX) begin
                        elapsed_d = elapsed_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // Phase state, elapsed sample count and first-result flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_WAIT_REF;
            elapsed_q <= '0;
            seen_q    <= 1'b0;
        end else begin
            st_q      <= st_d;
            elapsed_q <= elapsed_d;
            seen_q    <= seen_d;
        end
    end

    // Registered result and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_valid     <= 1'b0;
            meas_delay     <= '0;
            meas_ovf       <= 1'b0;
            miss_ref_pulse <= 1'b0;
            miss_sig_pulse <= 1'b0;
        end else begin
            meas_valid     <= done;
            miss_ref_pulse <= miss_r;
            miss_sig_pulse <= miss_s;
            if (done) begin
                meas_delay <= done_delay;
                meas_ovf   <= (done_delay == DMAX);
            end
        end
    end

    edm_sat_counter #(.WIDTH(MISS_W)) i_miss_ref_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .inc   (miss_r),
        .count (miss_ref_count)
    );

    edm_sat_counter #(.WIDTH(MISS_W)) i_miss_sig_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clear),
        .inc   (miss_s),
        .count (miss_sig_count)
    );

    // R10
    ovf_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_ovf) |-> (meas_delay == DMAX));

    // R6
    zero_stays_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_valid && meas_delay == '0) |-> (st_q == ST_WAIT_REF));

    // R9
    miss_ref_in_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ref_pulse |-> (st_q == ST_WAIT_SIG && !miss_sig_pulse));

    // R8
    miss_sig_no_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_sig_pulse |-> !meas_valid);

    // R5
    delay_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !meas_valid |-> ($stable(meas_delay) && $stable(meas_ovf)));

endmodule

// File: tb/test_edge_delay_meter.sv
module test_edge_delay_meter;

    localparam int DW   = 8;
    localparam int CW   = 5;
    localparam int DMAX = (1 << DW) - 1;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ref_mode = 2'd0;
    logic [1:0]    sig_mode = 2'd0;
    logic          cnt_clear = 1'b0;
    logic          ref_in = 1'b0;
    logic          sig_in = 1'b0;
    logic          meas_valid;
    logic [DW-1:0] meas_delay;
    logic          meas_ovf;
    logic          miss_ref_pulse;
    logic          miss_sig_pulse;
    logic [CW-1:0] miss_ref_count;
    logic [CW-1:0] miss_sig_count;

    always #2 clk = ~clk;

    edge_delay_meter #(.DELAY_W(DW), .MISS_W(CW), .SYNC_STAGES(2)) i_edge_delay_meter (
        .clk(clk), .rst_n(rst_n), .ref_mode(ref_mode), .sig_mode(sig_mode),
        .cnt_clear(cnt_clear), .ref_in(ref_in), .sig_in(sig_in),
        .meas_valid(meas_valid), .meas_delay(meas_delay), .meas_ovf(meas_ovf),
        .miss_ref_pulse(miss_ref_pulse), .miss_sig_pulse(miss_sig_pulse),
        .miss_ref_count(miss_ref_count), .miss_sig_count(miss_sig_count)
    );

    typedef struct {
        bit v; int d; bit o; bit pr; bit ps; int cr; int cs;
    } exp_t;

    exp_t  hist [4];
    exp_t  cur;
    exp_t  zero_e;
    int    k, ref_idx, n_cmp, n_bad;
    bit    primed, st, seen, prev_r, prev_s, fin, cur_r, cur_s;
    bit [1:0] rm, sm;
    string phase;

    function automatic bit edge_ok(bit [1:0] m, bit o, bit n);
        case (m)
            2'd0: return !o && n;
            2'd1: return o && !n;
            default: return o ^ n;
        endcase
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, phase, what, act, exp);
        end
    endtask

    task automatic check_out(exp_t e);
        cmp("R5",  "meas_valid",     int'(meas_valid),     int'(e.v));
        cmp("R5",  "meas_delay",     int'(meas_delay),     e.d);
        cmp("R10", "meas_ovf",       int'(meas_ovf),       int'(e.o));
        cmp("R9",  "miss_ref_pulse", int'(miss_ref_pulse), int'(e.pr));
        cmp("R8",  "miss_sig_pulse", int'(miss_sig_pulse), int'(e.ps));
        cmp("R11", "miss_ref_count", int'(miss_ref_count), e.cr);
        cmp("R11", "miss_sig_count", int'(miss_sig_count), e.cs);
    endtask

    // Reference model for one sample (R1, R3..R11).
    task automatic model(bit r, bit s);
        exp_t e;
        bit er, es;
        e = cur; e.v = 0; e.pr = 0; e.ps = 0;
        if (!primed) begin
            primed = 1;                       // R3: priming sample only
        end else begin
            er = edge_ok(rm, prev_r, r);
            es = edge_ok(sm, prev_s, s);
            if (!st) begin
                if (er && es) begin           // R6
                    e.v = 1; e.d = 0; e.o = 0; seen = 1;
                end else if (er) begin        // R4
                    st = 1; ref_idx = k;
                end else if (es && seen) begin
                    e.ps = 1;                 // R8
                    if (e.cs < CMAX) e.cs++;
                end
            end else begin
                if (es) begin                 // R5, R7, R10
                    e.v = 1; seen = 1;
                    e.d = k - ref_idx; e.o = 0;
                    if (e.d >= DMAX) begin e.d = DMAX; e.o = 1; end
                    if (er) ref_idx = k; else st = 0;
                end else if (er) begin
                    e.pr = 1;                 // R9
                    if (e.cr < CMAX) e.cr++;
                end
            end
        end
        prev_r = r; prev_s = s;
        cur = e;
        hist[k % 4] = e;
    endtask

    // One sample: drive, model, then compare the outputs of sample k-2.
    task automatic step(bit r, bit s, bit clr = 1'b0);
        ref_in = r; sig_in = s; cnt_clear = clr;
        cur_r = r; cur_s = s;
        if (clr && k >= 2) begin              // R12: clear wins at this edge
            hist[(k + 2) % 4].cr = 0;
            hist[(k + 2) % 4].cs = 0;
            hist[(k + 3) % 4].cr = int'(hist[(k + 3) % 4].pr);
            hist[(k + 3) % 4].cs = int'(hist[(k + 3) % 4].ps);
            cur.cr = hist[(k + 3) % 4].cr;
            cur.cs = hist[(k + 3) % 4].cs;
        end
        model(r, s);
        @(posedge clk);
        @(negedge clk);
        cnt_clear = 1'b0;
        check_out(hist[(k + 2) % 4]);
        k++;
    endtask

    // Hold reset with new edge modes, check outputs are zero (R13).
    task automatic do_reset(bit [1:0] m_ref, bit [1:0] m_sig);
        string saved;
        saved = phase;
        phase = "R13 reset";
        rst_n = 1'b0; ref_mode = m_ref; sig_mode = m_sig;
        rm = m_ref; sm = m_sig;
        for (int i = 0; i < 3; i++) begin
            ref_in = 1'($urandom_range(0, 1));
            sig_in = 1'($urandom_range(0, 1));
            @(posedge clk);
            @(negedge clk);
            check_out(zero_e);
        end
        rst_n = 1'b1;
        primed = 0; st = 0; seen = 0; k = 0; ref_idx = 0;
        cur = zero_e;
        for (int i = 0; i < 4; i++) hist[i] = zero_e;
        phase = saved;
    endtask

    task automatic rand_run(int n);
        for (int i = 0; i < n; i++) begin
            bit r, s, c;
            r = cur_r ^ ($urandom_range(0, 99) < 25);
            s = cur_s ^ ($urandom_range(0, 99) < 22);
            c = (k > 4) && ($urandom_range(0, 99) == 0);
            step(r, s, c);
        end
    endtask

    initial begin
        void'($urandom(32'd20240917));
        zero_e = '{0, 0, 0, 0, 0, 0, 0};
        n_cmp = 0; n_bad = 0; fin = 0; cur_r = 0; cur_s = 0;
        phase = "start";
        @(negedge clk);

        // R2 / R4 / R5: latency and a plain measurement
        do_reset(2'd0, 2'd0);
        phase = "R2 R4 latency";
        step(0, 0); step(0, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 1);
        step(1, 1); step(1, 1); step(1, 1);

        // R6: both edges on one sample give zero
        phase = "R6 same sample";
        step(0, 0); step(1, 1); step(1, 1); step(1, 1);

        // R7 and R9: restart on a joint edge, missed reference keeps start
        phase = "R7 R9 restart";
        step(0, 0); step(1, 0); step(1, 0); step(0, 0); step(1, 1);
        step(0, 1); step(1, 1); step(1, 0); step(1, 1); step(1, 1); step(1, 1);

        // R8: lone signal edges once a result exists
        phase = "R8 missed signal";
        step(1, 0); step(1, 1); step(1, 0); step(1, 1); step(1, 1); step(1, 1);

        // R10: saturation and the value just below it
        phase = "R10 saturation";
        step(0, 0); step(1, 0);
        for (int i = 0; i < 300; i++) step(1, 0);
        step(1, 1); step(1, 1);
        step(0, 0); step(1, 0);
        for (int i = 0; i < 253; i++) step(1, 0);
        step(1, 1); step(1, 1); step(1, 1);

        // R11 / R12: counters saturate and clear, clear beats an event
        do_reset(2'd2, 2'd3);
        phase = "R11 R12 counters";
        step(0, 0); step(1, 0);
        for (int i = 0; i < 40; i++) step((i % 2) == 0 ? 1'b0 : 1'b1, 0);
        step(0, 1);
        for (int i = 0; i < 40; i++) step(0, (i % 2) == 0 ? 1'b0 : 1'b1);
        step(0, 0); step(0, 0); step(0, 0, 1); step(0, 0); step(0, 0);
        step(0, 1); step(0, 0); step(0, 1, 1); step(0, 1); step(0, 1); step(0, 1);

        // R1: every edge-type pairing under random stimulus
        phase = "R1 modes random";
        for (int m = 0; m < 4; m++) begin
            do_reset(2'(m), 2'($urandom_range(0, 3)));
            rand_run(2500);
            do_reset(2'($urandom_range(0, 3)), 2'(m));
            rand_run(2500);
        end

        fin = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!fin) begin
            n_cmp++; n_bad++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule